// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block watches the control pins of a four-bank synchronous DRAM on every rising clock edge, turns each pin pattern into a named command and keeps a model of where every bank stands: idle, opening a row, open, closing or refreshing. It counts the row-open delay (tRCD), the close delay (tRP) and the refresh recovery (tRFC) in clock cycles and tracks the single read or write burst in flight. That lets it judge every command against the current bank state and the running burst.

A command that the state forbids raises a one-cycle illegal flag and has no effect on the tracked state. Legal commands move the bank model forward. The block sits beside a memory controller or on a bus monitor as a protocol checker and as a live view of bank occupancy. The decoded command, the flag and the bank states all appear one cycle after the edge that sampled the pins.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: Pins (cs_n, ras_n, cas_n, we_n) decode as: 0111 NOP (code 1), 0011 ACTIVATE (2), 0101 READ (3, or 4 with a10 high = auto-close), 0100 WRITE (5, or 6 with a10 high), 0010 PRECHARGE (7 with a10 low = one bank, 8 with a10 high = all banks), 0001 REFRESH (9 with cke high) or SELF-REFRESH (10 with cke low), 0000 MODE-SET (11), 0110 BURST-STOP (12). cke changes only the refresh pattern. cmd_o shows the code one cycle after the sampling edge.
- R2: With cs_n high the command is DESELECT (code 0), whatever the other pins carry. It is never illegal and changes no bank state.
- R3: NOP is never illegal and changes no bank state.
- R4: ACTIVATE to an idle bank moves it to OPENING (state code 1) and then to ACTIVE (code 2). A read or write to it is legal TRCD cycles after the ACTIVATE edge and illegal before. ACTIVATE to a bank that is not idle is illegal.
- R5: PRECHARGE with a10 low closes only the bank on ba. PRECHARGE with a10 high closes every ACTIVE bank and is illegal while any bank is OPENING, CLOSING or REFRESHING. A closed bank sits in CLOSING (code 3) and returns to IDLE (code 0), and ACTIVATE to it is illegal until TRP cycles after the PRECHARGE edge.
- R6: READ and WRITE of either kind are illegal unless the addressed bank is ACTIVE.
- R7: A read or write lasts BURST_LEN cycles counting its own edge. With auto-close, its bank enters CLOSING on the burst's last edge. During that burst, READ, WRITE, PRECHARGE (either kind) and BURST-STOP are illegal.
- R8: During a burst without auto-close, a single-bank PRECHARGE must name the burst's bank (it then ends the burst). Naming any other bank is illegal.
- R9: REFRESH, SELF-REFRESH and MODE-SET are legal only with all banks IDLE. REFRESH puts every bank in REFRESHING (code 4), and the next command is legal TRFC cycles after the REFRESH edge.
- R10: After SELF-REFRESH, all banks stay REFRESHING while cke is sampled low. The first edge that samples cke high starts the recovery, and a command is legal TRFC cycles after that edge.
- R11: An illegal command raises illegal_o for the cycle after its edge and causes none of the transitions it names. Timers and the end of an auto-close burst carry on.
- R12: While reset is held, cmd_o is DESELECT, illegal_o is low and every bank is IDLE. Bank b is reported on bank_state_o[3b+2:3b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, all pins sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable, selects refresh kind and self-refresh exit |
| a10 | input | 1 | Address bit 10: all-bank / auto-close qualifier |
| ba | input | 2 | Bank address |
| cmd_o | output | 4 | Decoded command code |
| bank_state_o | output | 12 | Three-bit state per bank |
| illegal_o | output | 1 | One-cycle flag for a forbidden command |

## Verification
The stimulus is a single command stream that runs each bank through open, access, close and refresh. Each command is placed one cycle before and exactly at its timing limit, which shows whether the tRCD, tRP and tRFC counts are off by one. Bursts with and without auto-close are interrupted by reads, precharges to the same and to a foreign bank, and burst-stop. This separates the auto-close lockout from the same-bank rule. Deselect cycles carrying an activate pattern, and refresh requests with a bank open, show that ignored or refused commands leave the bank states as they were.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_RDA   = 4'd4,
    CMD_WR    = 4'd5,
    CMD_WRA   = 4'd6,
    CMD_PRE   = 4'd7,
    CMD_PREA  = 4'd8,
    CMD_REF   = 4'd9,
    CMD_SREF  = 4'd10,
    CMD_MRS   = 4'd11,
    CMD_BST   = 4'd12
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_OPEN   = 3'd1,
    BK_ACTIVE = 3'd2,
    BK_PRECH  = 3'd3,
    BK_REFR   = 3'd4
  } bank_st_e;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic a10,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_DESEL;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = a10 ? CMD_RDA : CMD_RD;
        3'b100:  cmd = a10 ? CMD_WRA : CMD_WR;
        3'b010:  cmd = a10 ? CMD_PREA : CMD_PRE;
        3'b001:  cmd = cke ? CMD_REF : CMD_SREF;
        3'b000:  cmd = CMD_MRS;
        default: cmd = CMD_BST;
      endcase
    end
  end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int TRCD = 3,
  parameter int TRP  = 3,
  parameter int TRFC = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     do_act,
  input  logic     do_close,
  input  logic     do_ref,
  input  logic     hold_refresh,
  output bank_st_e state
);

  localparam int MAXT = (TRFC > TRCD) ? ((TRFC > TRP) ? TRFC : TRP)
                                      : ((TRCD > TRP) ? TRCD : TRP);
  localparam int CW = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LD_RCD = CW'(TRCD - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(TRP - 1);
  localparam logic [CW-1:0] LD_RFC = CW'(TRFC - 1);
  localparam logic [CW-1:0] ONE    = CW'(1);

  bank_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      BK_IDLE: begin
        if (do_ref) begin
          st_d  = BK_REFR;
          cnt_d = LD_RFC;
        end else if (do_act) begin
          st_d  = BK_OPEN;
          cnt_d = LD_RCD;
        end
      end
      BK_OPEN: begin
        if (cnt_q == ONE) st_d = BK_ACTIVE;
        else              cnt_d = cnt_q - ONE;
      end
      BK_ACTIVE: begin
        if (do_close) begin
          st_d  = BK_PRECH;
          cnt_d = LD_RP;
        end
      end
      BK_PRECH: begin
        if (cnt_q == ONE) st_d = BK_IDLE;
        else              cnt_d = cnt_q - ONE;
      end
      BK_REFR: begin
        if (hold_refresh)     cnt_d = LD_RFC;
        else if (cnt_q == ONE) st_d = BK_IDLE;
        else                   cnt_d = cnt_q - ONE;
      end
      default: st_d = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;

  // an opening row can only finish opening
  assert_open_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == BK_OPEN |=> (st_q == BK_OPEN || st_q == BK_ACTIVE));

  // a closing bank can only end up idle
  assert_close_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == BK_PRECH |=> (st_q == BK_PRECH || st_q == BK_IDLE));

  // an idle bank moves only when commanded
  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == BK_IDLE && !do_act && !do_ref) |=> st_q == BK_IDLE);

endmodule

// File: rtl/sdcmd_burst.sv
module sdcmd_burst #(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  localparam int BAW = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 auto_close,
  input  logic [BAW-1:0]       start_bank,
  input  logic                 stop,
  output logic                 live,
  output logic                 live_auto,
  output logic [BAW-1:0]       live_bank,
  output logic [NUM_BANKS-1:0] close_pulse
);

  localparam int BCW = $clog2(BURST_LEN + 1);
  localparam logic [BCW-1:0] LD_BL = BCW'(BURST_LEN - 1);
  localparam logic [BCW-1:0] ONE   = BCW'(1);

  logic           live_q, live_d;
  logic           ap_q, ap_d;
  logic [BAW-1:0] bank_q, bank_d;
  logic [BCW-1:0] cnt_q, cnt_d;
  logic           end_now;

  assign end_now = live_q && (cnt_q == ONE);

  always_comb begin
    live_d = live_q;
    ap_d   = ap_q;
    bank_d = bank_q;
    cnt_d  = cnt_q;
    if (start) begin
      live_d = 1'b1;
      ap_d   = auto_close;
      bank_d = start_bank;
      cnt_d  = LD_BL;
    end else if (stop || end_now) begin
      live_d = 1'b0;
      ap_d   = 1'b0;
    end else if (live_q) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      ap_q   <= 1'b0;
      bank_q <= '0;
      cnt_q  <= '0;
    end else begin
      live_q <= live_d;
      ap_q   <= ap_d;
      bank_q <= bank_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_close
    assign close_pulse[b] = end_now && ap_q && (bank_q == BAW'(b));
  end

  assign live      = live_q;
  assign live_auto = ap_q;
  assign live_bank = bank_q;

  // a burst runs its full length unless cut short or replaced
  assert_burst_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && cnt_q != ONE && !start && !stop) |=> live_q);

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdcmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TRCD      = 3,
  parameter int TRP       = 3,
  parameter int TRFC      = 6,
  parameter int BURST_LEN = 4,
  localparam int BAW = $clog2(NUM_BANKS),
  localparam int SW  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    ras_n,
  input  logic                    cas_n,
  input  logic                    we_n,
  input  logic                    cke,
  input  logic                    a10,
  input  logic [BAW-1:0]          ba,
  output logic [3:0]              cmd_o,
  output logic [NUM_BANKS*SW-1:0] bank_state_o,
  output logic                    illegal_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_i  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_i  <= rst_s1;
    end
  end

  cmd_e dec;
  sdcmd_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke  (cke),  .a10  (a10),   .cmd  (dec)
  );

  bank_st_e             st [NUM_BANKS];
  logic [NUM_BANKS-1:0] do_act, do_close, ap_close;
  logic                 do_ref;
  logic                 sref_q, sref_d;
  logic                 burst_live, burst_auto, burst_start, burst_stop, start_auto;
  logic [BAW-1:0]       burst_bank;
  logic                 legal;
  logic                 all_idle, all_settled, all_refr;
  bank_st_e             sel_st;
  logic                 ap_busy;
  cmd_e                 cmd_q;
  logic                 ill_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdcmd_bank #(.TRCD(TRCD), .TRP(TRP), .TRFC(TRFC)) u_bank (
      .clk         (clk),
      .rst_n       (rst_i),
      .do_act      (do_act[b]),
      .do_close    (do_close[b]),
      .do_ref      (do_ref),
      .hold_refresh(sref_q),
      .state       (st[b])
    );
    assign bank_state_o[SW*b +: SW] = st[b];
  end

  sdcmd_burst #(.NUM_BANKS(NUM_BANKS), .BURST_LEN(BURST_LEN)) u_burst (
    .clk        (clk),
    .rst_n      (rst_i),
    .start      (burst_start),
    .auto_close (start_auto),
    .start_bank (ba),
    .stop       (burst_stop),
    .live       (burst_live),
    .live_auto  (burst_auto),
    .live_bank  (burst_bank),
    .close_pulse(ap_close)
  );

  // summary of bank states
  always_comb begin
    all_idle    = 1'b1;
    all_settled = 1'b1;
    all_refr    = 1'b1;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (st[b] != BK_IDLE) all_idle = 1'b0;
      if (st[b] != BK_IDLE && st[b] != BK_ACTIVE) all_settled = 1'b0;
      if (st[b] != BK_REFR) all_refr = 1'b0;
    end
  end

  assign sel_st  = st[ba];
  assign ap_busy = burst_live && burst_auto;

  // legality against the state table
  always_comb begin
    case (dec)
      CMD_ACT:  legal = (sel_st == BK_IDLE);
      CMD_RD, CMD_RDA, CMD_WR, CMD_WRA:
                legal = (sel_st == BK_ACTIVE) && !ap_busy;
      CMD_PRE:  legal = (sel_st == BK_IDLE || sel_st == BK_ACTIVE) && !ap_busy &&
                        !(burst_live && ba != burst_bank);
      CMD_PREA: legal = all_settled && !ap_busy;
      CMD_REF, CMD_SREF, CMD_MRS:
                legal = all_idle;
      CMD_BST:  legal = !ap_busy;
      default:  legal = 1'b1;
    endcase
  end

  // effects of a legal command
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      do_act[b]   = legal && dec == CMD_ACT && ba == BAW'(b);
      do_close[b] = (legal && ((dec == CMD_PRE && ba == BAW'(b)) || dec == CMD_PREA)) ||
                    ap_close[b];
    end
    do_ref      = legal && (dec == CMD_REF || dec == CMD_SREF);
    burst_start = legal && (dec == CMD_RD || dec == CMD_RDA ||
                            dec == CMD_WR || dec == CMD_WRA);
    start_auto  = (dec == CMD_RDA || dec == CMD_WRA);
    burst_stop  = legal && (dec == CMD_BST || dec == CMD_PRE || dec == CMD_PREA);
    sref_d      = sref_q;
    if (sref_q && cke)                 sref_d = 1'b0;
    else if (legal && dec == CMD_SREF) sref_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      cmd_q  <= CMD_DESEL;
      ill_q  <= 1'b0;
      sref_q <= 1'b0;
    end else begin
      cmd_q  <= dec;
      ill_q  <= !legal;
      sref_q <= sref_d;
    end
  end

  assign cmd_o     = cmd_q;
  assign illegal_o = ill_q;

  // a deselected cycle reports DESELECT and is never refused
  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_i)
    cs_n |=> (cmd_q == CMD_DESEL && !ill_q));

  // the flag never accompanies an idle command
  assert_nop_never_flagged_R3: assert property (@(posedge clk) disable iff (!rst_i)
    ill_q |-> (cmd_q != CMD_NOP && cmd_q != CMD_DESEL));

  // the bank of a running burst stays open
  assert_burst_bank_open_R8: assert property (@(posedge clk) disable iff (!rst_i)
    burst_live |-> st[burst_bank] == BK_ACTIVE);

  // self refresh keeps every bank refreshing
  assert_sref_all_banks_R10: assert property (@(posedge clk) disable iff (!rst_i)
    sref_q |-> all_refr);

endmodule

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
  import sdcmd_pkg::*;

  localparam int SI = 0, SO = 1, SA = 2, SP = 3, SR = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n, cke, a10;
  logic [1:0]  ba;
  logic [3:0]  cmd_o;
  logic [11:0] bank_state_o;
  logic        illegal_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [3:0]  q_cmd[$];
  logic        q_ill[$];
  logic [11:0] q_vec[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  sdram_cmd_tracker dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .a10(a10), .ba(ba), .cmd_o(cmd_o),
    .bank_state_o(bank_state_o), .illegal_o(illegal_o)
  );

  function automatic logic [11:0] v(int s3, int s2, int s1, int s0);
    return {3'(s3), 3'(s2), 3'(s1), 3'(s0)};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: set pins from the R1 table, push the expected result
  task automatic step(cmd_e c, int b, logic ck, logic exp_ill, logic [11:0] exp_v,
                      string tag, logic [2:0] dpins = 3'b000);
    @(negedge clk);
    cs_n = 1'b0; cke = ck; ba = 2'(b); a10 = 1'b0;
    case (c)
      CMD_DESEL: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = dpins; end
      CMD_NOP:   {ras_n, cas_n, we_n} = 3'b111;
      CMD_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      CMD_RD:    {ras_n, cas_n, we_n} = 3'b101;
      CMD_RDA:   begin {ras_n, cas_n, we_n} = 3'b101; a10 = 1'b1; end
      CMD_WR:    {ras_n, cas_n, we_n} = 3'b100;
      CMD_WRA:   begin {ras_n, cas_n, we_n} = 3'b100; a10 = 1'b1; end
      CMD_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      CMD_PREA:  begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b1; end
      CMD_REF:   {ras_n, cas_n, we_n} = 3'b001;
      CMD_SREF:  {ras_n, cas_n, we_n} = 3'b001;
      CMD_MRS:   {ras_n, cas_n, we_n} = 3'b000;
      default:   {ras_n, cas_n, we_n} = 3'b110;
    endcase
    q_cmd.push_back(c);
    q_ill.push_back(exp_ill);
    q_vec.push_back(exp_v);
    q_tag.push_back(tag);
  endtask

  // monitor: after each edge, compare against the oldest expectation
  always @(posedge clk) begin
    #2;
    if (q_cmd.size() > 0) begin
      string t;
      t = q_tag.pop_front();
      chk(t, "cmd", 32'(cmd_o), 32'(q_cmd.pop_front()));
      chk(t, "illegal", 32'(illegal_o), 32'(q_ill.pop_front()));
      chk(t, "banks", 32'(bank_state_o), 32'(q_vec.pop_front()));
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    cke = 1'b1; a10 = 1'b0; ba = 2'd0;
    repeat (3) @(posedge clk);
    #2;
    chk("R12", "cmd", 32'(cmd_o), 32'(CMD_DESEL));
    chk("R12", "illegal", 32'(illegal_o), 32'd0);
    chk("R12", "banks", 32'(bank_state_o), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(CMD_DESEL, 0, 1, 0, v(SI,SI,SI,SI), "R2");
    step(CMD_NOP,   0, 1, 0, v(SI,SI,SI,SI), "R3");
    step(CMD_ACT,   1, 1, 0, v(SI,SI,SO,SI), "R4");
    step(CMD_ACT,   1, 1, 1, v(SI,SI,SO,SI), "R4");
    step(CMD_RD,    1, 1, 1, v(SI,SI,SA,SI), "R6");   // one cycle before tRCD
    step(CMD_RD,    1, 1, 0, v(SI,SI,SA,SI), "R4");   // exactly at tRCD
    step(CMD_ACT,   2, 1, 0, v(SI,SO,SA,SI), "R1");
    step(CMD_PRE,   0, 1, 1, v(SI,SO,SA,SI), "R8");   // foreign bank during burst
    step(CMD_PRE,   1, 1, 0, v(SI,SA,SP,SI), "R8");   // same bank interrupts
    step(CMD_ACT,   1, 1, 1, v(SI,SA,SP,SI), "R5");   // inside tRP
    step(CMD_NOP,   0, 1, 0, v(SI,SA,SI,SI), "R5");
    step(CMD_ACT,   1, 1, 0, v(SI,SA,SO,SI), "R5");   // exactly at tRP
    step(CMD_WRA,   2, 1, 0, v(SI,SA,SO,SI), "R7");
    step(CMD_RD,    2, 1, 1, v(SI,SA,SA,SI), "R7");
    step(CMD_PRE,   2, 1, 1, v(SI,SA,SA,SI), "R7");
    step(CMD_BST,   0, 1, 1, v(SI,SP,SA,SI), "R7");   // auto-close lands anyway
    step(CMD_NOP,   0, 1, 0, v(SI,SP,SA,SI), "R7");
    step(CMD_NOP,   0, 1, 0, v(SI,SI,SA,SI), "R7");
    step(CMD_REF,   0, 1, 1, v(SI,SI,SA,SI), "R9");   // bank still open
    step(CMD_PREA,  3, 1, 0, v(SI,SI,SP,SI), "R5");
    step(CMD_NOP,   0, 1, 0, v(SI,SI,SP,SI), "R5");
    step(CMD_NOP,   0, 1, 0, v(SI,SI,SI,SI), "R5");
    step(CMD_REF,   0, 1, 0, v(SR,SR,SR,SR), "R9");
    step(CMD_NOP,   0, 1, 0, v(SR,SR,SR,SR), "R9");
    step(CMD_ACT,   0, 1, 1, v(SR,SR,SR,SR), "R11");
    step(CMD_NOP,   0, 1, 0, v(SR,SR,SR,SR), "R9");
    step(CMD_NOP,   0, 1, 0, v(SR,SR,SR,SR), "R9");
    step(CMD_ACT,   0, 1, 1, v(SI,SI,SI,SI), "R9");   // one cycle before tRFC
    step(CMD_MRS,   0, 1, 0, v(SI,SI,SI,SI), "R9");   // exactly at tRFC
    step(CMD_SREF,  0, 0, 0, v(SR,SR,SR,SR), "R10");
    step(CMD_NOP,   0, 0, 0, v(SR,SR,SR,SR), "R10");
    step(CMD_SREF,  0, 0, 1, v(SR,SR,SR,SR), "R10");
    step(CMD_NOP,   0, 1, 0, v(SR,SR,SR,SR), "R10");  // first cke high edge
    for (int k = 0; k < 4; k++) step(CMD_NOP, 0, 1, 0, v(SR,SR,SR,SR), "R10");
    step(CMD_ACT,   3, 1, 1, v(SI,SI,SI,SI), "R10");
    step(CMD_ACT,   3, 1, 0, v(SO,SI,SI,SI), "R10");
    step(CMD_PREA,  0, 1, 1, v(SO,SI,SI,SI), "R5");   // bank still opening
    step(CMD_NOP,   0, 1, 0, v(SA,SI,SI,SI), "R4");
    step(CMD_RDA,   3, 1, 0, v(SA,SI,SI,SI), "R7");
    step(CMD_ACT,   0, 1, 0, v(SA,SI,SI,SO), "R4");
    step(CMD_NOP,   0, 1, 0, v(SA,SI,SI,SO), "R7");
    step(CMD_NOP,   0, 1, 0, v(SP,SI,SI,SA), "R7");   // last burst edge closes
    step(CMD_NOP,   0, 1, 0, v(SP,SI,SI,SA), "R7");
    step(CMD_NOP,   0, 1, 0, v(SI,SI,SI,SA), "R7");
    step(CMD_DESEL, 3, 1, 0, v(SI,SI,SI,SA), "R2", 3'b011); // activate pins ignored
    step(CMD_NOP,   0, 1, 0, v(SI,SI,SI,SA), "R3");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule